// File: doc/BRIEF.md
# Double-Buffered Energy Histogrammer

This block builds an energy spectrum for one detector channel. Each accepted event carries a 20-bit energy. The energy is shifted down by a programmable base, divided by a power-of-two bin width and counted into one of 2048 bins. Each bin holds a saturating counter.

Two pages of bins alternate. One page accumulates while the other holds the last finished spectrum for readout. A seconds counter driven by a one-second strobe ends each measurement period, and the pages then exchange roles. Clearing the readout page is done either by hardware at period end or by a user command. An optional stop mode halts accumulation when a period ends before the user has cleared the readout page. At each exchange the unit reports the lowest and highest occupied bin of the finished page and whether that page received any event.

After reset the unit zeroes both pages before it accepts events. Settings are plain level inputs and the clear command is a one-cycle pulse. The readout port returns the count of the addressed bin of the readout page one clock after the address is presented.

Top module: `hist_unit`

## Requirements
- R1: An accepted energy e with e >= base is counted in bin (e - base) >> shift, where base is 20 bits and shift is 0..15, provided that result is at most 2047.
- R2: An energy below base is counted in bin 0. An energy whose shifted offset exceeds 2047 is counted in bin 2047.
- R3: A bin counter that holds its maximum value (all ones, CNT_W bits) stays at that value on further hits.
- R4: After reset, busy_o is high for exactly 2048 cycles while both pages are zeroed. Energies are ignored during this time. Afterwards active_page_o is 0, cleared_o is 1, and sec_cnt_o and meas_cnt_o are 0.
- R5: sec_cnt_o advances by one on each strobe and runs from 0 to meas_time-1. The strobe seen at meas_time-1 ends the period and returns sec_cnt_o to 0. meas_cnt_o increments by one at every page exchange.
- R6: At a page exchange active_page_o toggles. The finished page becomes the readout page, and rd_data_o shows the count at rd_addr_i one clock after the address.
- R7: With clear mode 0, period end starts a hardware clear of the readout page with busy_o high. The exchange follows once the clear completes. Energies arriving meanwhile count into the still-active page.
- R8: With clear mode 1, a clear pulse zeroes the readout page and cleared_o rises when that clear finishes. cleared_o falls at the exchange. If cleared_o is high at period end, the exchange follows without a further clear.
- R9: With clear mode 1 and hist mode 1, a period that ends while cleared_o is low raises stalled_o. While stalled, energies and strobes are ignored and no exchange occurs. A user clear then releases the exchange.
- R10: With clear mode 1 and hist mode 0, the pages exchange at period end without any clear. The newly active page keeps its old counts and adds to them.
- R11: At each exchange, first_bin_o and last_bin_o take the lowest and highest bin hit during the ended period (zero-extended to 16 bits), and not_empty_o shows whether any hit occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| energy_valid_i | input | 1 | Energy event present this cycle |
| energy_i | input | 20 | Event energy |
| sec_strobe_i | input | 1 | One-cycle pulse per second |
| e_min_i | input | 20 | Histogram base energy |
| e_bin_i | input | 4 | Bin width as a right-shift amount |
| meas_time_i | input | 32 | Measurement period in seconds |
| hist_mode_i | input | 1 | 1: stall if readout page not cleared (clear mode 1 only) |
| clr_mode_i | input | 1 | 0: hardware clear, 1: user clear |
| clr_cmd_i | input | 1 | User clear pulse for the readout page |
| rd_addr_i | input | 11 | Readout bin address |
| rd_data_o | output | CNT_W | Readout bin count, one cycle latency |
| active_page_o | output | 1 | Index of the accumulating page |
| cleared_o | output | 1 | Readout page has been zeroed since the last exchange |
| busy_o | output | 1 | A clear or the reset zeroing is running |
| stalled_o | output | 1 | Accumulation halted, waiting for user clear |
| not_empty_o | output | 1 | Finished page received at least one event |
| first_bin_o | output | 16 | Lowest occupied bin of finished page |
| last_bin_o | output | 16 | Highest occupied bin of finished page |
| sec_cnt_o | output | 32 | Seconds elapsed in current period |
| meas_cnt_o | output | 32 | Number of completed periods |

## Verification
Energies are placed exactly on bin edges (base, base+3, base+4), below the base, at the top in-range bin, one step past it, and far above it. These patterns separate the shift arithmetic from the two clamps. A burst of twenty hits on one bin exceeds the counter range and tells saturation apart from wrap-around. The same energies are then replayed across four periods, each with a different clear/stop mode combination. The readout contents of each page show which page received an event sent during a stall, during a clear, or just after an exchange without a clear.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    CLR_IDLE = 2'd0,
    CLR_INIT = 2'd1,
    CLR_RUN  = 2'd2
  } clr_state_e;
endpackage

// File: rtl/hist_bin_map.sv
module hist_bin_map #(
  parameter int E_W   = 20,
  parameter int SH_W  = 4,
  parameter int BIN_W = 11
) (
  input  logic [E_W-1:0]   energy_i,
  input  logic [E_W-1:0]   base_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [BIN_W-1:0] bin_o
);
  logic [E_W:0]   diff;
  logic [E_W-1:0] scaled;
  logic           below, above;

  always_comb begin
    diff   = {1'b0, energy_i} - {1'b0, base_i};
    below  = diff[E_W];
    scaled = diff[E_W-1:0] >> shift_i;
    above  = |scaled[E_W-1:BIN_W];
    if (below)      bin_o = '0;
    else if (above) bin_o = '1;
    else            bin_o = scaled[BIN_W-1:0];
  end
endmodule

// File: rtl/hist_page.sv
module hist_page #(
  parameter int BIN_W = 11,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [BIN_W-1:0] waddr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [BIN_W-1:0] raddr_a_i,
  output logic [CNT_W-1:0] rdata_a_o,
  input  logic [BIN_W-1:0] raddr_b_i,
  output logic [CNT_W-1:0] rdata_b_o
);
  localparam int NBINS = 1 << BIN_W;
  logic [CNT_W-1:0] mem [NBINS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int BIN_W = 11,
  parameter int T_W   = 32,
  parameter int M_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_strobe_i,
  input  logic [T_W-1:0]   meas_time_i,
  input  logic             hist_mode_i,
  input  logic             clr_mode_i,
  input  logic             clr_cmd_i,
  output logic             active_o,
  output logic             swap_o,
  output logic             init_o,
  output logic             clr_we_o,
  output logic [BIN_W-1:0] clr_addr_o,
  output logic             busy_o,
  output logic             cleared_o,
  output logic             stalled_o,
  output logic [T_W-1:0]   sec_cnt_o,
  output logic [M_W-1:0]   meas_cnt_o
);
  localparam logic [BIN_W-1:0] LAST = '1;

  clr_state_e       st_q;
  logic [BIN_W-1:0] addr_q;
  logic             active_q, pend_q, auto_q, cleared_q;
  logic [T_W-1:0]   sec_q;
  logic [M_W-1:0]   meas_q;
  logic             busy, period_end, clr_start, swap, stalled;

  assign busy       = (st_q != CLR_IDLE);
  assign period_end = sec_strobe_i && !pend_q &&
                      (({1'b0, sec_q} + 1'b1) >= {1'b0, meas_time_i});
  assign clr_start  = (clr_cmd_i || auto_q) && !busy;
  assign stalled    = pend_q && clr_mode_i && hist_mode_i && !cleared_q;
  // exchange waits for any clear and yields to one about to start
  assign swap       = pend_q && !busy && !clr_start &&
                      (cleared_q || (clr_mode_i && !hist_mode_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= CLR_INIT;
      addr_q    <= '0;
      active_q  <= 1'b0;
      pend_q    <= 1'b0;
      auto_q    <= 1'b0;
      cleared_q <= 1'b0;
      sec_q     <= '0;
      meas_q    <= '0;
    end else begin
      if (period_end) begin
        sec_q  <= '0;
        pend_q <= 1'b1;
      end else if (sec_strobe_i && !pend_q) begin
        sec_q <= sec_q + 1'b1;
      end
      auto_q <= (auto_q && !clr_start) || (period_end && !clr_mode_i);

      if (swap) begin
        pend_q    <= 1'b0;
        active_q  <= ~active_q;
        meas_q    <= meas_q + 1'b1;
        cleared_q <= 1'b0;
      end

      if (clr_start) begin
        st_q      <= CLR_RUN;
        addr_q    <= '0;
        cleared_q <= 1'b0;
      end else if (busy) begin
        addr_q <= addr_q + 1'b1;
        if (addr_q == LAST) begin
          st_q      <= CLR_IDLE;
          cleared_q <= 1'b1;
        end
      end
    end
  end

  assign active_o   = active_q;
  assign swap_o     = swap;
  assign init_o     = (st_q == CLR_INIT);
  assign clr_we_o   = busy;
  assign clr_addr_o = addr_q;
  assign busy_o     = busy;
  assign cleared_o  = cleared_q;
  assign stalled_o  = stalled;
  assign sec_cnt_o  = sec_q;
  assign meas_cnt_o = meas_q;

  assert_sec_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_time_i != '0 && $stable(meas_time_i)) |-> (sec_q < meas_time_i));
  assert_meas_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> (meas_q == $past(meas_q) + 1'b1));
  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled |=> $stable(active_q));
  assert_cleared_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> !cleared_q);
  assert_no_swap_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(active_q));
endmodule

// File: rtl/hist_unit.sv
module hist_unit #(
  parameter int E_W   = 20,
  parameter int SH_W  = 4,
  parameter int BIN_W = 11,
  parameter int CNT_W = 32,
  parameter int T_W   = 32,
  parameter int M_W   = 32,
  parameter int POS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             energy_valid_i,
  input  logic [E_W-1:0]   energy_i,
  input  logic             sec_strobe_i,
  input  logic [E_W-1:0]   e_min_i,
  input  logic [SH_W-1:0]  e_bin_i,
  input  logic [T_W-1:0]   meas_time_i,
  input  logic             hist_mode_i,
  input  logic             clr_mode_i,
  input  logic             clr_cmd_i,
  input  logic [BIN_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             active_page_o,
  output logic             cleared_o,
  output logic             busy_o,
  output logic             stalled_o,
  output logic             not_empty_o,
  output logic [POS_W-1:0] first_bin_o,
  output logic [POS_W-1:0] last_bin_o,
  output logic [T_W-1:0]   sec_cnt_o,
  output logic [M_W-1:0]   meas_cnt_o
);
  localparam int NPAGES = 2;

  logic             active, swap, init, clr_we, busy, stalled;
  logic [BIN_W-1:0] clr_addr, acc_bin;
  logic             acc_we;
  logic [CNT_W-1:0] cnt_a [NPAGES];
  logic [CNT_W-1:0] cnt_b [NPAGES];
  logic [CNT_W-1:0] cur, nxt;

  hist_ctrl #(.BIN_W(BIN_W), .T_W(T_W), .M_W(M_W)) u_ctrl (
    .clk_i, .rst_ni, .sec_strobe_i, .meas_time_i, .hist_mode_i, .clr_mode_i,
    .clr_cmd_i, .active_o(active), .swap_o(swap), .init_o(init),
    .clr_we_o(clr_we), .clr_addr_o(clr_addr), .busy_o(busy),
    .cleared_o(cleared_o), .stalled_o(stalled), .sec_cnt_o(sec_cnt_o),
    .meas_cnt_o(meas_cnt_o)
  );

  hist_bin_map #(.E_W(E_W), .SH_W(SH_W), .BIN_W(BIN_W)) u_map (
    .energy_i, .base_i(e_min_i), .shift_i(e_bin_i), .bin_o(acc_bin)
  );

  assign acc_we = energy_valid_i && !stalled && !init;
  assign cur    = cnt_a[active];
  assign nxt    = (&cur) ? cur : cur + 1'b1;

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    logic             is_act, we;
    logic [BIN_W-1:0] waddr;
    logic [CNT_W-1:0] wdata;
    assign is_act = (active == 1'(p)) && !init;
    assign we     = is_act ? acc_we : clr_we;
    assign waddr  = is_act ? acc_bin : clr_addr;
    assign wdata  = is_act ? nxt : '0;
    hist_page #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_pg (
      .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
      .raddr_a_i(acc_bin), .rdata_a_o(cnt_a[p]),
      .raddr_b_i(rd_addr_i), .rdata_b_o(cnt_b[p])
    );
  end

  // occupancy of the page being filled, handed over at exchange
  logic [BIN_W-1:0] first_q, last_q, nf, nl, out_first_q, out_last_q;
  logic             hit_q, nh, out_ne_q;

  always_comb begin
    nf = first_q;
    nl = last_q;
    if (acc_we && (!hit_q || acc_bin < first_q)) nf = acc_bin;
    if (acc_we && (!hit_q || acc_bin > last_q))  nl = acc_bin;
    nh = hit_q || acc_we;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q     <= '0;
      last_q      <= '0;
      hit_q       <= 1'b0;
      out_first_q <= '0;
      out_last_q  <= '0;
      out_ne_q    <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      if (swap) begin
        out_first_q <= nf;
        out_last_q  <= nl;
        out_ne_q    <= nh;
        first_q     <= '0;
        last_q      <= '0;
        hit_q       <= 1'b0;
      end else begin
        first_q <= nf;
        last_q  <= nl;
        hit_q   <= nh;
      end
      rd_data_o <= cnt_b[!active];
    end
  end

  assign active_page_o = active;
  assign busy_o        = busy;
  assign stalled_o     = stalled;
  assign not_empty_o   = out_ne_q;
  assign first_bin_o   = POS_W'(out_first_q);
  assign last_bin_o    = POS_W'(out_last_q);

  assert_low_clamp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (energy_valid_i && energy_i < e_min_i) |-> (acc_bin == '0));
  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we |-> (nxt != '0));
  assert_order_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ne_q |-> (out_first_q <= out_last_q));
  assert_init_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init |-> !acc_we);
endmodule

// File: tb/sim_hist_unit.sv
`timescale 1ns/1ps
module sim_hist_unit;
  localparam int CW = 4;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          energy_valid_i = 1'b0;
  logic [19:0]   energy_i = '0;
  logic          sec_strobe_i = 1'b0;
  logic [19:0]   e_min_i = 20'd1000;
  logic [3:0]    e_bin_i = 4'd2;
  logic [31:0]   meas_time_i = 32'd2;
  logic          hist_mode_i = 1'b0, clr_mode_i = 1'b1, clr_cmd_i = 1'b0;
  logic [10:0]   rd_addr_i = '0;
  logic [CW-1:0] rd_data_o;
  logic          active_page_o, cleared_o, busy_o, stalled_o, not_empty_o;
  logic [15:0]   first_bin_o, last_bin_o;
  logic [31:0]   sec_cnt_o, meas_cnt_o;

  hist_unit #(.CNT_W(CW)) u0 (.*);

  always #5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  int    sb_addr[$];
  int    sb_exp[$];
  string sb_req[$];

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_bin(input int a, input int v, input string req);
    sb_addr.push_back(a); sb_exp.push_back(v); sb_req.push_back(req);
  endtask

  // monitor: pops expected bins and compares readout results
  task automatic drain();
    while (sb_addr.size() > 0) begin
      int a, v; string r;
      a = sb_addr.pop_front(); v = sb_exp.pop_front(); r = sb_req.pop_front();
      rd_addr_i = 11'(a);
      @(negedge clk_i);
      chk(r, int'(rd_data_o), v);
    end
  endtask

  task automatic send(input int e);
    energy_i = 20'(e); energy_valid_i = 1'b1;
    @(negedge clk_i);
    energy_valid_i = 1'b0;
  endtask

  task automatic strobe();
    sec_strobe_i = 1'b1;
    @(negedge clk_i);
    sec_strobe_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic wait_page(input logic pg, input string req);
    int k = 0;
    while (active_page_o != pg && k < 6000) begin @(negedge clk_i); k++; end
    chk(req, int'(active_page_o), int'(pg));
    @(negedge clk_i);
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy_o && k < 6000) begin @(negedge clk_i); k++; end
  endtask

  initial begin
    int cnt;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    cnt = 0;
    while (busy_o && cnt < 5000) begin
      send(1400);  // ignored during zeroing
      cnt++;
    end
    chk("R4 init length", cnt, 2048);
    chk("R4 active page", int'(active_page_o), 0);
    chk("R4 cleared", int'(cleared_o), 1);
    chk("R4 meas cnt", int'(meas_cnt_o), 0);
    chk("R4 sec cnt", int'(sec_cnt_o), 0);

    // period A: clear mode 1, stop mode 0, readout page already clear
    send(1000); send(1003); send(500);          // bin0 x3 (R1, R2 low)
    send(1004);                                  // bin1
    send(1400); send(1400); send(1400);          // bin100
    send(9188); send(9192); send(200000);        // bin2047 x3 (R2 high)
    for (int i = 0; i < 20; i++) send(1020);     // bin5 saturates
    strobe();
    chk("R5 sec after one strobe", int'(sec_cnt_o), 1);
    strobe();
    wait_page(1'b1, "R6 exchange A");
    chk("R5 meas cnt A", int'(meas_cnt_o), 1);
    chk("R5 sec wrapped", int'(sec_cnt_o), 0);
    chk("R8 cleared drops", int'(cleared_o), 0);
    chk("R11 not empty A", int'(not_empty_o), 1);
    chk("R11 first A", int'(first_bin_o), 0);
    chk("R11 last A", int'(last_bin_o), 2047);
    expect_bin(0, 3, "R2 bin0 clamp");
    expect_bin(1, 1, "R1 bin1");
    expect_bin(2, 0, "R1 bin2 empty");
    expect_bin(100, 3, "R1 bin100");
    expect_bin(5, 15, "R3 saturation");
    expect_bin(2047, 3, "R2 bin2047 clamp");
    expect_bin(1, 1, "R1 bin1 reread");
    drain();

    // period B: stop mode, readout page not cleared
    hist_mode_i = 1'b1;
    send(1028);                                  // bin7
    strobe(); strobe();
    chk("R9 stalled", int'(stalled_o), 1);
    send(1032);                                  // bin8, must be ignored
    strobe();
    chk("R9 timer frozen", int'(sec_cnt_o), 0);
    chk("R9 no exchange", int'(active_page_o), 1);
    clr_cmd_i = 1'b1; @(negedge clk_i); clr_cmd_i = 1'b0;
    wait_idle();
    wait_page(1'b0, "R9 exchange after user clear");
    chk("R9 stall released", int'(stalled_o), 0);
    chk("R11 first B", int'(first_bin_o), 7);
    chk("R11 last B", int'(last_bin_o), 7);
    chk("R5 meas cnt B", int'(meas_cnt_o), 2);
    expect_bin(7, 1, "R9 bin7 before stall");
    expect_bin(8, 0, "R9 stalled energy ignored");
    drain();

    // period C: continuous mode, no clear; page0 was user-cleared
    hist_mode_i = 1'b0;
    send(1036); send(1036);                      // bin9
    strobe(); strobe();
    wait_page(1'b1, "R10 exchange without clear");
    expect_bin(9, 2, "R10 bin9");
    expect_bin(0, 0, "R8 user clear zeroed bin0");
    expect_bin(100, 0, "R8 user clear zeroed bin100");
    drain();
    chk("R11 first C", int'(first_bin_o), 9);

    // period D: hardware clear; page1 still holds bin7=1
    clr_mode_i = 1'b0;
    send(1028);
    strobe(); strobe();
    chk("R7 clear running", int'(busy_o), 1);
    send(1028);                                  // counted into active page1
    chk("R7 no exchange during clear", int'(active_page_o), 1);
    wait_page(1'b0, "R7 exchange after hw clear");
    chk("R5 meas cnt D", int'(meas_cnt_o), 4);
    chk("R11 last D", int'(last_bin_o), 7);
    expect_bin(7, 3, "R10 old counts kept, R7 energy during clear");
    expect_bin(9, 0, "R10 page1 never had bin9");
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule